// File: doc/BRIEF.md
# Wireless Power Transmitter Phase Sequencer

This block steps a wireless power transmitter through its protocol phases. It watches for an object on the pad and probes it with an analog ping and then a digital ping. It collects identification and configuration, and it negotiates and calibrates when the receiver asks for it. It then holds the transmitter in power transfer until an end packet, a fault or a timeout ends the session. The packet decoder and the power control loop are outside the block. They deliver single-cycle event strobes to it, and they take back a power-enable, a drive request and a flag that caps delivery at the baseline 5 W profile.

Two 8-bit codes are presented for a host register interface. One is the current phase, which uses a fixed numbering. The other is the reason the last session was torn down, and it holds its value until the next teardown or a reset. Every teardown passes through a power-removal phase. That phase keeps the power-enable low for a hold-off count that software sets, then passes through a restart phase and back to idle.

Top module: `wpt_phase_ctrl`

## Requirements
- R1: While rst_n is low, state_code is 0 (startup), status_code is 0 and pwr_en, drive_req and base_only are 0. On the first clock edge after reset is released, state_code becomes 1 (idle).
- R2: In idle (1), obj_det moves the sequencer to analog ping (2). In analog ping, obj_det moves it on to digital ping (4), and without obj_det it returns to idle.
- R3: In digital ping (4), ss_pkt moves it to identification (5). rsp_timeout without ss_pkt returns it to idle (1) without a teardown, and status_code keeps its value.
- R4: In identification (5), cfg_rx moves it to configuration (7). From configuration, neg_req leads to negotiation (13). Without neg_req it goes directly to power transfer (9) with base_only = 1.
- R5: In negotiation (13) entered from configuration, neg_ok leads to calibration (8). In calibration, cal_ok leads to power transfer (9) with base_only = 0.
- R6: In power transfer that was reached through negotiation, neg_req enters negotiation (13), and neg_ok there returns straight to power transfer (9). In baseline power transfer, neg_req is ignored.
- R7: An ept_valid in any powered state (4, 5, 7, 13, 8, 9) goes to power removal (11). The status is set from ept_why: 0 gives 2 (charge complete), 1 gives 5 (internal fault), and 2 or 3 gives 9 (other receiver fault).
- R8: In a powered state, fod_det leads to removal with status 1. neg_fail in negotiation gives status 10. cal_fail in calibration gives status 5. rsp_timeout in states 5, 7, 13, 8 or 9 gives status 4.
- R9: When several causes are raised in the same cycle, the status follows a fixed priority order: over_temp (6), then over_curr (7), then fod_det, then ept_valid, then the negotiation and calibration failures, then the timeout. Outside the powered states, the fault inputs are ignored.
- R10: In power removal (11), pwr_en is 0 for exactly hold_cyc+1 cycles. The sequencer then spends one cycle in restart (12) and returns to idle (1).
- R11: status_code changes only on entry to power removal. It keeps its value through restart and idle, and only reset clears it to 0.
- R12: pwr_en is 1 exactly in states 4, 5, 7, 13, 8 and 9. drive_req is 1 exactly in states 8 and 9. base_only is 1 only in power transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obj_det | input | 1 | Object present on the pad |
| ss_pkt | input | 1 | Signal-strength packet received correctly |
| cfg_rx | input | 1 | Configuration packet received |
| neg_req | input | 1 | Receiver requests (re)negotiation |
| neg_ok | input | 1 | Negotiation completed successfully |
| neg_fail | input | 1 | Negotiation failed |
| cal_ok | input | 1 | Calibration succeeded |
| cal_fail | input | 1 | Calibration failed |
| ept_valid | input | 1 | End-power-transfer packet received |
| ept_why | input | 2 | Reason carried by the end packet |
| fod_det | input | 1 | Foreign object detected |
| over_temp | input | 1 | Over-temperature fault |
| over_curr | input | 1 | Over-current fault |
| rsp_timeout | input | 1 | Receiver response timed out |
| hold_cyc | input | HOLD_W | Power-removal hold-off count |
| pwr_en | output | 1 | Power stage enable |
| drive_req | output | 1 | Request to the power loop to drive the coil |
| base_only | output | 1 | Cap delivery at the baseline profile |
| state_code | output | 8 | Current phase code |
| status_code | output | 8 | Latched teardown reason |

## Verification
Several teardown causes can arrive in the same cycle, for example a thermal fault together with an end packet and a foreign-object flag. The bench raises such causes together in power transfer and removes the strongest one on each further pass. It judges the latched status against the priority order. It also pairs neg_req with a baseline session and a timeout with digital ping, and checks that each of these takes the path the requirements give and does not tear the session down.

// File: rtl/wpt_phase_pkg.sv
// Shared phase and status encodings for the wireless power phase sequencer.
// Assumes the numeric values are fixed because a host register map decodes them.
package wpt_phase_pkg;

    typedef enum logic [7:0] {
        PH_STARTUP = 8'd0,
        PH_IDLE    = 8'd1,
        PH_APING   = 8'd2,
        PH_DPING   = 8'd4,
        PH_IDENT   = 8'd5,
        PH_CONFIG  = 8'd7,
        PH_PT_INIT = 8'd8,
        PH_PT      = 8'd9,
        PH_REMOVE  = 8'd11,
        PH_RESTART = 8'd12,
        PH_NEGO    = 8'd13
    } phase_e;

    typedef enum logic [7:0] {
        ST_NORMAL   = 8'd0,
        ST_FOD      = 8'd1,
        ST_EPT_DONE = 8'd2,
        ST_EPT_NORSP= 8'd4,
        ST_EPT_INT  = 8'd5,
        ST_OTP      = 8'd6,
        ST_OCP      = 8'd7,
        ST_EPT_OTH  = 8'd9,
        ST_NEG_FAIL = 8'd10
    } status_e;

    // True in phases where the power signal is applied to the coil.
    function automatic logic is_powered(input phase_e p);
        return (p == PH_DPING) || (p == PH_IDENT) || (p == PH_CONFIG) ||
               (p == PH_NEGO)  || (p == PH_PT_INIT) || (p == PH_PT);
    endfunction

endpackage

// File: rtl/wpt_fault_pick.sv
// Priority selector for session teardown causes.
// Assumes the caller has already masked the inputs by phase; pure combinational.
module wpt_fault_pick
    import wpt_phase_pkg::*;
(
    input  logic       over_temp,
    input  logic       over_curr,
    input  logic       fod,
    input  logic       ept,
    input  logic [1:0] ept_why,
    input  logic       neg_fail,
    input  logic       cal_fail,
    input  logic       tmo,
    output logic       hit,
    output status_e    code
);

    // Pick the strongest active cause; thermal and current faults lead.
    always_comb begin
        hit  = 1'b1;
        code = ST_NORMAL;
        if (over_temp)      code = ST_OTP;
        else if (over_curr) code = ST_OCP;
        else if (fod)       code = ST_FOD;
        else if (ept) begin
            unique case (ept_why)
                2'd0:    code = ST_EPT_DONE;
                2'd1:    code = ST_EPT_INT;
                default: code = ST_EPT_OTH;
            endcase
        end
        else if (neg_fail)  code = ST_NEG_FAIL;
        else if (cal_fail)  code = ST_EPT_INT;
        else if (tmo)       code = ST_EPT_NORSP;
        else                hit  = 1'b0;
    end

endmodule

// File: rtl/wpt_holdoff_timer.sv
// Down-counter that times the power-removal hold-off.
// Assumes load is a single-cycle pulse; done is high while the count is zero.
module wpt_holdoff_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/wpt_phase_ctrl.sv
// Protocol phase sequencer for a wireless power transmitter.
// Takes single-cycle event strobes from the packet decoder and protection logic,
// and drives the power enable, the drive request, the baseline cap and two host codes.
// Assumes all inputs are synchronous to clk.
module wpt_phase_ctrl
    import wpt_phase_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obj_det,
    input  logic              ss_pkt,
    input  logic              cfg_rx,
    input  logic              neg_req,
    input  logic              neg_ok,
    input  logic              neg_fail,
    input  logic              cal_ok,
    input  logic              cal_fail,
    input  logic              ept_valid,
    input  logic [1:0]        ept_why,
    input  logic              fod_det,
    input  logic              over_temp,
    input  logic              over_curr,
    input  logic              rsp_timeout,
    input  logic [HOLD_W-1:0] hold_cyc,
    output logic              pwr_en,
    output logic              drive_req,
    output logic              base_only,
    output logic [7:0]        state_code,
    output logic [7:0]        status_code
);

    phase_e  state, state_n;
    status_e status_q;
    logic    reneg_q, reneg_n;
    logic    base_q, base_n;
    logic    powered;
    logic    f_hit;
    status_e f_code;
    logic    hold_done;
    logic    enter_remove;

    assign powered = is_powered(state);

    wpt_fault_pick u_pick (
        .over_temp (powered & over_temp),
        .over_curr (powered & over_curr),
        .fod       (powered & fod_det),
        .ept       (powered & ept_valid),
        .ept_why   (ept_why),
        .neg_fail  ((state == PH_NEGO) & neg_fail),
        .cal_fail  ((state == PH_PT_INIT) & cal_fail),
        .tmo       (powered & (state != PH_DPING) & rsp_timeout),
        .hit       (f_hit),
        .code      (f_code)
    );

    assign enter_remove = (state_n == PH_REMOVE) && (state != PH_REMOVE);

    wpt_holdoff_timer #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_remove),
        .load_val (hold_cyc),
        .done     (hold_done)
    );

    // Next-phase decision; teardown causes outrank every packet event.
    always_comb begin
        state_n = state;
        reneg_n = reneg_q;
        if (f_hit) begin
            state_n = PH_REMOVE;
        end else begin
            unique case (state)
                PH_STARTUP: state_n = PH_IDLE;
                PH_IDLE:    if (obj_det) state_n = PH_APING;
                PH_APING:   state_n = obj_det ? PH_DPING : PH_IDLE;
                PH_DPING: begin
                    if (ss_pkt)           state_n = PH_IDENT;
                    else if (rsp_timeout) state_n = PH_IDLE;
                end
                PH_IDENT:   if (cfg_rx) state_n = PH_CONFIG;
                PH_CONFIG: begin
                    reneg_n = 1'b0;
                    state_n = neg_req ? PH_NEGO : PH_PT;
                end
                PH_NEGO:    if (neg_ok) state_n = reneg_q ? PH_PT : PH_PT_INIT;
                PH_PT_INIT: if (cal_ok) state_n = PH_PT;
                PH_PT: begin
                    if (neg_req && !base_q) begin
                        state_n = PH_NEGO;
                        reneg_n = 1'b1;
                    end
                end
                PH_REMOVE:  if (hold_done) state_n = PH_RESTART;
                PH_RESTART: state_n = PH_IDLE;
                default:    state_n = PH_STARTUP;
            endcase
        end
    end

    // Baseline flag is set by skipping negotiation and kept only while in transfer.
    always_comb begin
        base_n = ((state == PH_CONFIG) && (state_n == PH_PT)) ||
                 ((state == PH_PT) && (state_n == PH_PT) && base_q);
    end

    // Phase, renegotiation and baseline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_STARTUP;
            reneg_q <= 1'b0;
            base_q  <= 1'b0;
        end else begin
            state   <= state_n;
            reneg_q <= reneg_n;
            base_q  <= base_n;
        end
    end

    // Teardown reason latch; written only when power removal begins.
    always_ff @(posedge clk) begin
        if (!rst_n)            status_q <= ST_NORMAL;
        else if (enter_remove) status_q <= f_code;
    end

    assign pwr_en      = powered;
    assign drive_req   = (state == PH_PT_INIT) || (state == PH_PT);
    assign base_only   = base_q;
    assign state_code  = state;
    assign status_code = status_q;

endmodule

// File: rtl/wpt_phase_ctrl_chk.sv
// Assertion checker for the phase sequencer, bound to its top module.
// Observes ports only; assumes synchronous active-low reset.
module wpt_phase_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ss_pkt,
    input logic       over_temp,
    input logic       pwr_en,
    input logic       drive_req,
    input logic       base_only,
    input logic [7:0] state_code,
    input logic [7:0] status_code
);

    logic pw;
    assign pw = (state_code == 8'd4) || (state_code == 8'd5) || (state_code == 8'd7) ||
                (state_code == 8'd13) || (state_code == 8'd8) || (state_code == 8'd9);

    p_off_in_remove_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'd11) |-> !pwr_en);

    p_restart_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'd12) |=> (state_code == 8'd1));

    p_status_only_on_remove_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_code) |-> (state_code == 8'd11));

    p_ident_needs_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_code) == 8'd4 && state_code == 8'd5) |-> $past(ss_pkt));

    p_otp_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pw && over_temp) |=> (state_code == 8'd11 && status_code == 8'd6));

    p_drive_powered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        drive_req |-> pwr_en);

    p_base_in_pt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        base_only |-> (state_code == 8'd9));

endmodule

bind wpt_phase_ctrl wpt_phase_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_pkt      (ss_pkt),
    .over_temp   (over_temp),
    .pwr_en      (pwr_en),
    .drive_req   (drive_req),
    .base_only   (base_only),
    .state_code  (state_code),
    .status_code (status_code)
);

// File: tb/test_wpt_phase_ctrl.sv
// Directed bench for the phase sequencer: one task per scenario, each self-checking.
module test_wpt_phase_ctrl;

    localparam int HW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic obj_det = 0, ss_pkt = 0, cfg_rx = 0, neg_req = 0, neg_ok = 0, neg_fail = 0;
    logic cal_ok = 0, cal_fail = 0, ept_valid = 0, fod_det = 0, over_temp = 0;
    logic over_curr = 0, rsp_timeout = 0;
    logic [1:0] ept_why = 2'd0;
    logic [HW-1:0] hold_cyc = 8'd3;
    logic pwr_en, drive_req, base_only;
    logic [7:0] state_code, status_code;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wpt_phase_ctrl #(.HOLD_W(HW)) i_wpt_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .obj_det(obj_det), .ss_pkt(ss_pkt), .cfg_rx(cfg_rx),
        .neg_req(neg_req), .neg_ok(neg_ok), .neg_fail(neg_fail), .cal_ok(cal_ok),
        .cal_fail(cal_fail), .ept_valid(ept_valid), .ept_why(ept_why), .fod_det(fod_det),
        .over_temp(over_temp), .over_curr(over_curr), .rsp_timeout(rsp_timeout),
        .hold_cyc(hold_cyc), .pwr_en(pwr_en), .drive_req(drive_req), .base_only(base_only),
        .state_code(state_code), .status_code(status_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        ss_pkt = 0; cfg_rx = 0; neg_req = 0; neg_ok = 0; neg_fail = 0; cal_ok = 0;
        cal_fail = 0; ept_valid = 0; fod_det = 0; over_temp = 0; over_curr = 0;
        rsp_timeout = 0;
    endtask

    // Walk from idle to identification.
    task automatic to_ident();
        obj_det = 1; tick(); tick();
        ss_pkt = 1; tick(); ss_pkt = 0;
    endtask

    // Walk from idle to transfer, baseline or through negotiation and calibration.
    task automatic to_pt(input bit nego);
        to_ident();
        cfg_rx = 1; tick(); cfg_rx = 0;
        if (nego) begin
            neg_req = 1; tick(); neg_req = 0;
            neg_ok = 1; tick(); neg_ok = 0;
            cal_ok = 1; tick(); cal_ok = 0;
        end else begin
            tick();
        end
    endtask

    task automatic back_to_idle();
        for (int i = 0; i < 300 && state_code != 8'd1; i++) tick();
        check("R10 return to idle", state_code, 1);
    endtask

    task automatic t_reset();
        check("R1 state", state_code, 0);
        check("R1 status", status_code, 0);
        check("R1 outputs", {pwr_en, drive_req, base_only}, 0);
        rst_n = 1; tick();
        check("R1 idle after reset", state_code, 1);
    endtask

    task automatic t_select();
        obj_det = 1; tick();
        check("R2 analog ping", state_code, 2);
        check("R12 no power in aping", pwr_en, 0);
        obj_det = 0; tick();
        check("R2 back to idle", state_code, 1);
        over_temp = 1; tick(); clear_in();
        check("R9 fault ignored in idle", state_code, 1);
        check("R9 status untouched in idle", status_code, 0);
        obj_det = 1; tick(); tick();
        check("R2 digital ping", state_code, 4);
        check("R12 power in dping", pwr_en, 1);
        rsp_timeout = 1; tick(); rsp_timeout = 0;
        check("R3 dping timeout to idle", state_code, 1);
        check("R3 status kept", status_code, 0);
    endtask

    task automatic t_baseline();
        to_ident();
        check("R3 ident", state_code, 5);
        cfg_rx = 1; tick(); cfg_rx = 0;
        check("R4 config", state_code, 7);
        tick();
        check("R4 baseline transfer", state_code, 9);
        check("R4 base_only", base_only, 1);
        check("R12 drive in pt", drive_req, 1);
        neg_req = 1; tick(); neg_req = 0;
        check("R6 reneg ignored in baseline", state_code, 9);
        ept_why = 2'd0; ept_valid = 1; tick(); ept_valid = 0;
        check("R7 ept remove", state_code, 11);
        check("R7 charge complete", status_code, 2);
        check("R4 base cleared", base_only, 0);
        back_to_idle();
        check("R11 status kept in idle", status_code, 2);
    endtask

    task automatic t_nego();
        to_ident();
        cfg_rx = 1; tick(); cfg_rx = 0;
        neg_req = 1; tick(); neg_req = 0;
        check("R4 negotiation", state_code, 13);
        neg_ok = 1; tick(); neg_ok = 0;
        check("R5 calibration", state_code, 8);
        check("R12 drive in calib", drive_req, 1);
        cal_ok = 1; tick(); cal_ok = 0;
        check("R5 transfer", state_code, 9);
        check("R5 not baseline", base_only, 0);
        neg_req = 1; tick(); neg_req = 0;
        check("R6 renegotiation", state_code, 13);
        check("R12 no drive in nego", drive_req, 0);
        neg_ok = 1; tick(); neg_ok = 0;
        check("R6 straight back to pt", state_code, 9);
        ept_why = 2'd1; ept_valid = 1; tick(); ept_valid = 0;
        check("R7 internal fault", status_code, 5);
        back_to_idle();
    endtask

    task automatic t_hold();
        int cnt;
        hold_cyc = 8'd3;
        to_pt(0);
        fod_det = 1; tick(); fod_det = 0;
        check("R8 fod status", status_code, 1);
        cnt = 0;
        while (state_code == 8'd11 && cnt < 300) begin
            if (pwr_en) check("R10 power off in remove", pwr_en, 0);
            cnt++; tick();
        end
        check("R10 hold length", cnt, 4);
        check("R10 restart", state_code, 12);
        tick();
        check("R10 idle after restart", state_code, 1);
        hold_cyc = 8'd0;
        to_pt(0);
        ept_why = 2'd3; ept_valid = 1; tick(); ept_valid = 0;
        check("R7 other receiver fault", status_code, 9);
        tick();
        check("R10 zero hold", state_code, 12);
        back_to_idle();
        hold_cyc = 8'd2;
    endtask

    task automatic t_fail_paths();
        to_ident(); cfg_rx = 1; tick(); cfg_rx = 0;
        neg_req = 1; tick(); neg_req = 0;
        neg_fail = 1; tick(); neg_fail = 0;
        check("R8 negotiation fail", status_code, 10);
        back_to_idle();
        to_ident(); cfg_rx = 1; tick(); cfg_rx = 0;
        neg_req = 1; tick(); neg_req = 0;
        neg_ok = 1; tick(); neg_ok = 0;
        cal_fail = 1; tick(); cal_fail = 0;
        check("R8 calibration fail", status_code, 5);
        back_to_idle();
        to_ident();
        rsp_timeout = 1; tick(); rsp_timeout = 0;
        check("R8 timeout in ident", state_code, 11);
        check("R8 timeout status", status_code, 4);
        back_to_idle();
    endtask

    task automatic t_priority();
        to_pt(1);
        over_temp = 1; over_curr = 1; fod_det = 1; ept_valid = 1; ept_why = 0;
        tick(); clear_in();
        check("R9 otp wins", status_code, 6);
        back_to_idle();
        to_pt(1);
        over_curr = 1; fod_det = 1; ept_valid = 1; tick(); clear_in();
        check("R9 ocp over fod", status_code, 7);
        back_to_idle();
        to_pt(1);
        fod_det = 1; ept_valid = 1; rsp_timeout = 1; tick(); clear_in();
        check("R9 fod over ept", status_code, 1);
        back_to_idle();
        to_pt(1);
        ept_valid = 1; ept_why = 0; rsp_timeout = 1; tick(); clear_in();
        check("R9 ept over timeout", status_code, 2);
        back_to_idle();
        to_pt(1);
        neg_req = 1; tick(); neg_req = 0;
        neg_fail = 1; rsp_timeout = 1; tick(); clear_in();
        check("R9 neg fail over timeout", status_code, 10);
        back_to_idle();
    endtask

    initial begin
        clear_in();
        tick(); tick();
        t_reset();
        t_select();
        t_baseline();
        t_nego();
        t_hold();
        t_fail_paths();
        t_priority();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule